// File: doc/BRIEF.md
# Keyboard Controller Command Engine

This block is the host-side register and command engine of a PC-style keyboard controller. The host reaches it through one byte-wide write port. A select bit picks either the data register or the command register. A command byte is decoded in the cycle it is accepted. Depending on the byte, the block does one of the following:

- updates the mode register, the output port register or the status register;
- produces a reply byte;
- requests a system reset;
- arms a deferred write, which decides what the next data-port byte means.

The output port register drives the A20 gate directly. Mode bit 6 drives the scan-code translation enable. Reply bytes leave on a valid/ready interface toward the output buffer, with a tag that marks them as keyboard or auxiliary data. Bytes meant for the attached devices leave as single-cycle strobes.

The block holds at most one reply. While a reply is waiting, the host write port shows not-ready, so no command is lost and none overtakes the reply.

Top module: `kbc_cmd_engine`

## Requirements
- R1: After reset the mode register is 0x03, the status register is 0x18, the output port is 0xCF, the A20 gate is high, no reply is pending and the host port is ready.
- R2: Some commands produce one reply, tagged keyboard (aux tag 0):
  - 0x20 replies with the mode register.
  - 0xAA sets status bit 2 and replies 0x55.
  - 0xA9 and 0xAB reply 0x00.
  - 0xC0 replies 0x80.
  - 0xD0 replies with the output port.
- R3: Command 0xA7 sets mode bit 5 and 0xA8 clears it. Command 0xAD sets mode bit 4 and 0xAE clears it. No other mode bit changes, and none of these commands replies.
- R4: Commands 0x60, 0xD1, 0xD2, 0xD3 and 0xD4 only arm a deferred write. The next data-port byte is then routed by the armed code, and the armed code is cleared:
  - 0x60 loads the mode register.
  - 0xD1 loads the output port.
  - 0xD2 replies with the byte tagged keyboard.
  - 0xD3 replies with the byte tagged auxiliary (aux tag 1).
  - 0xD4 strobes the byte toward the auxiliary device.
- R5: With nothing armed, a data-port byte is strobed toward the keyboard device for one cycle.
- R6: Command 0xDF sets output port bit 1 and raises A20. Command 0xDD clears bit 1 and lowers A20.
- R7: A byte loaded into the output port drives A20 from its bit 1. If its bit 0 is 0, a one-cycle system reset request is issued.
- R8: A command byte whose upper nibble is 0xF issues a one-cycle reset request when its bit 0 is 0, and does nothing when bit 0 is 1.
- R9: An unsupported command code changes no register and produces no reply.
- R10: While a reply is pending, the host port is not ready. The reply data and tag hold steady until the reply is accepted.
- R11: The translation enable output follows mode bit 6 after every mode load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr_valid | input | 1 | Host write request |
| host_wr_ready | output | 1 | Host write accepted when high |
| host_sel | input | 1 | 1 = command register, 0 = data register |
| host_wdata | input | 8 | Byte written by the host |
| status_o | output | 8 | Status register |
| rsp_valid | output | 1 | Reply byte available |
| rsp_ready | input | 1 | Output buffer takes the reply |
| rsp_data | output | 8 | Reply byte |
| rsp_aux | output | 1 | Reply tag: 0 keyboard, 1 auxiliary |
| dev_tx_data | output | 8 | Byte sent toward a device |
| kbd_tx_valid | output | 1 | One-cycle strobe: byte for the keyboard |
| aux_tx_valid | output | 1 | One-cycle strobe: byte for the auxiliary device |
| a20_gate | output | 1 | A20 gate, output port bit 1 |
| sys_reset_req | output | 1 | One-cycle system reset request |
| xlate_en | output | 1 | Scan-code translation enable, mode bit 6 |

## Verification
The hardest state to reach is the deferred write. The meaning of a data byte there depends on a command that was accepted earlier, possibly with reply traffic in between. The stimulus therefore pairs every arming command with its data byte and then reads the effect back through commands 0x20 and 0xD0. A second data byte follows each pair to show that the armed code was cleared. Back-pressure is produced by holding the output buffer not-ready for several cycles while a reply waits.

// File: rtl/kbc_pkg.sv
// Shared constants and record types for the keyboard controller command engine.
// Assumes byte-wide host accesses.
package kbc_pkg;
    localparam int BYTE_W = 8;

    // Result of decoding one command byte.
    typedef struct packed {
        logic              reply;
        logic [BYTE_W-1:0] rdata;
        logic              arm;
        logic [BYTE_W-1:0] mode_set;
        logic [BYTE_W-1:0] mode_clr;
        logic              a20_on;
        logic              a20_off;
        logic              rst;
        logic              selftest;
    } cmd_act_t;

    // Result of routing one data-port byte.
    typedef struct packed {
        logic load_mode;
        logic load_outp;
        logic reply;
        logic reply_aux;
        logic aux_tx;
        logic kbd_tx;
    } dat_act_t;
endpackage

// File: rtl/kbc_cmd_decode.sv
// Combinational decoder for command-port bytes.
// Folds pulse commands (upper nibble all ones) into reset or no-op first.
// Codes it does not know give an all-zero action.
module kbc_cmd_decode
    import kbc_pkg::*;
(
    input  logic [BYTE_W-1:0] cmd,
    input  logic [BYTE_W-1:0] mode,
    input  logic [BYTE_W-1:0] outp,
    output cmd_act_t          act
);
    localparam logic [BYTE_W-1:0] BIT4 = BYTE_W'(1) << 4;
    localparam logic [BYTE_W-1:0] BIT5 = BYTE_W'(1) << 5;

    logic [BYTE_W-1:0] eff;

    // Fold the pulse group into its two effective codes.
    always_comb begin
        eff = cmd;
        if (cmd[BYTE_W-1 -: 4] == 4'hF) eff = cmd[0] ? 8'hFF : 8'hFE;
    end

    // Map the effective code to an action.
    always_comb begin
        act = '0;
        unique case (eff)
            8'h20: begin act.reply = 1'b1; act.rdata = mode; end
            8'h60, 8'hD1, 8'hD2, 8'hD3, 8'hD4: act.arm = 1'b1;
            8'hA7: act.mode_set = BIT5;
            8'hA8: act.mode_clr = BIT5;
            8'hAD: act.mode_set = BIT4;
            8'hAE: act.mode_clr = BIT4;
            8'hA9, 8'hAB: begin act.reply = 1'b1; act.rdata = 8'h00; end
            8'hAA: begin act.reply = 1'b1; act.rdata = 8'h55; act.selftest = 1'b1; end
            8'hC0: begin act.reply = 1'b1; act.rdata = 8'h80; end
            8'hD0: begin act.reply = 1'b1; act.rdata = outp; end
            8'hDF: act.a20_on  = 1'b1;
            8'hDD: act.a20_off = 1'b1;
            8'hFE: act.rst     = 1'b1;
            default: act = '0;
        endcase
    end
endmodule

// File: rtl/kbc_data_route.sv
// Combinational router for data-port bytes.
// The stored deferred-write code picks the destination; zero means keyboard.
module kbc_data_route
    import kbc_pkg::*;
(
    input  logic [BYTE_W-1:0] pend,
    output dat_act_t          act
);
    // Select the destination from the armed code.
    always_comb begin
        act = '0;
        unique case (pend)
            8'h60: act.load_mode = 1'b1;
            8'hD1: act.load_outp = 1'b1;
            8'hD2: act.reply     = 1'b1;
            8'hD3: begin act.reply = 1'b1; act.reply_aux = 1'b1; end
            8'hD4: act.aux_tx    = 1'b1;
            default: act.kbd_tx  = 1'b1;
        endcase
    end
endmodule

// File: rtl/kbc_state_regs.sv
// Mode, output-port, status and deferred-write registers, plus the reset strobe.
// Assumes cmd_go and data_go are never high together.
module kbc_state_regs
    import kbc_pkg::*;
#(
    parameter logic [BYTE_W-1:0] MODE_RST = 8'h03,
    parameter logic [BYTE_W-1:0] STAT_RST = 8'h18,
    parameter logic [BYTE_W-1:0] OUTP_RST = 8'hCF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_go,
    input  logic              data_go,
    input  logic [BYTE_W-1:0] wdata,
    input  cmd_act_t          cact,
    input  dat_act_t          dact,
    output logic [BYTE_W-1:0] mode_q,
    output logic [BYTE_W-1:0] outp_q,
    output logic [BYTE_W-1:0] stat_q,
    output logic [BYTE_W-1:0] pend_q,
    output logic              rst_req_q
);
    // Apply decoded command and data actions to the held state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q    <= MODE_RST;
            outp_q    <= OUTP_RST;
            stat_q    <= STAT_RST;
            pend_q    <= '0;
            rst_req_q <= 1'b0;
        end else begin
            rst_req_q <= 1'b0;
            if (cmd_go) begin
                mode_q <= (mode_q & ~cact.mode_clr) | cact.mode_set;
                if (cact.a20_on)   outp_q[1] <= 1'b1;
                if (cact.a20_off)  outp_q[1] <= 1'b0;
                if (cact.selftest) stat_q[2] <= 1'b1;
                if (cact.arm)      pend_q    <= wdata;
                if (cact.rst)      rst_req_q <= 1'b1;
            end
            if (data_go) begin
                pend_q <= '0;
                if (dact.load_mode) mode_q <= wdata;
                if (dact.load_outp) begin
                    outp_q    <= wdata;
                    rst_req_q <= ~wdata[0];
                end
            end
        end
    end
endmodule

// File: rtl/kbc_reply_slot.sv
// One-entry reply holding register with a valid/ready output.
// Assumes load is only asserted while the slot is empty.
module kbc_reply_slot
    import kbc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BYTE_W-1:0] ld_data,
    input  logic              ld_aux,
    input  logic              ready,
    output logic              valid,
    output logic [BYTE_W-1:0] data,
    output logic              aux
);
    // Capture a reply and release it on handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            data  <= '0;
            aux   <= 1'b0;
        end else if (load) begin
            valid <= 1'b1;
            data  <= ld_data;
            aux   <= ld_aux;
        end else if (valid && ready) begin
            valid <= 1'b0;
        end
    end
endmodule

// File: rtl/kbc_cmd_engine.sv
// Top of the keyboard controller command engine.
// Accepts host bytes only while the reply slot is empty, so each accepted
// write can emit at most one reply without loss.
module kbc_cmd_engine
    import kbc_pkg::*;
#(
    parameter logic [BYTE_W-1:0] MODE_RST = 8'h03,
    parameter logic [BYTE_W-1:0] STAT_RST = 8'h18,
    parameter logic [BYTE_W-1:0] OUTP_RST = 8'hCF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr_valid,
    output logic              host_wr_ready,
    input  logic              host_sel,
    input  logic [BYTE_W-1:0] host_wdata,
    output logic [BYTE_W-1:0] status_o,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [BYTE_W-1:0] rsp_data,
    output logic              rsp_aux,
    output logic [BYTE_W-1:0] dev_tx_data,
    output logic              kbd_tx_valid,
    output logic              aux_tx_valid,
    output logic              a20_gate,
    output logic              sys_reset_req,
    output logic              xlate_en
);
    logic              acc, cmd_go, data_go;
    logic [BYTE_W-1:0] mode_q, outp_q, pend_q;
    cmd_act_t          cact;
    dat_act_t          dact;

    assign host_wr_ready = ~rsp_valid;
    assign acc           = host_wr_valid & host_wr_ready;
    assign cmd_go        = acc & host_sel;
    assign data_go       = acc & ~host_sel;
    assign a20_gate      = outp_q[1];
    assign xlate_en      = mode_q[6];

    kbc_cmd_decode u_dec (
        .cmd (host_wdata),
        .mode(mode_q),
        .outp(outp_q),
        .act (cact)
    );

    kbc_data_route u_route (
        .pend(pend_q),
        .act (dact)
    );

    kbc_state_regs #(
        .MODE_RST(MODE_RST),
        .STAT_RST(STAT_RST),
        .OUTP_RST(OUTP_RST)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_go   (cmd_go),
        .data_go  (data_go),
        .wdata    (host_wdata),
        .cact     (cact),
        .dact     (dact),
        .mode_q   (mode_q),
        .outp_q   (outp_q),
        .stat_q   (status_o),
        .pend_q   (pend_q),
        .rst_req_q(sys_reset_req)
    );

    logic              rep_load, rep_aux;
    logic [BYTE_W-1:0] rep_data;

    // Choose the reply source: command decode or deferred data routing.
    always_comb begin
        rep_load = (cmd_go & cact.reply) | (data_go & dact.reply);
        rep_data = cmd_go ? cact.rdata : host_wdata;
        rep_aux  = data_go & dact.reply_aux;
    end

    kbc_reply_slot u_slot (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (rep_load),
        .ld_data(rep_data),
        .ld_aux (rep_aux),
        .ready  (rsp_ready),
        .valid  (rsp_valid),
        .data   (rsp_data),
        .aux    (rsp_aux)
    );

    // Register device-bound strobes and their byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kbd_tx_valid <= 1'b0;
            aux_tx_valid <= 1'b0;
            dev_tx_data  <= '0;
        end else begin
            kbd_tx_valid <= data_go & dact.kbd_tx;
            aux_tx_valid <= data_go & dact.aux_tx;
            if (data_go) dev_tx_data <= host_wdata;
        end
    end
endmodule

// File: rtl/kbc_cmd_engine_chk.sv
// Temporal checks on the command engine, attached by bind.
module kbc_cmd_engine_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       host_wr_valid,
    input logic       host_wr_ready,
    input logic       host_sel,
    input logic       rsp_valid,
    input logic       rsp_ready,
    input logic [7:0] rsp_data,
    input logic       rsp_aux,
    input logic       kbd_tx_valid,
    input logic       aux_tx_valid,
    input logic       a20_gate,
    input logic       sys_reset_req,
    input logic [7:0] mode_q
);
    logic acc;
    assign acc = host_wr_valid && host_wr_ready;

    a_r10_no_accept_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !host_wr_ready);
    a_r10_reply_held: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_aux));
    a_r9_reply_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rsp_valid) |-> $past(acc));
    a_r7_a20_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(a20_gate) |-> $past(acc));
    a_r8_reset_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        sys_reset_req |-> $past(acc));
    a_r5_kbd_tx_from_data: assert property (@(posedge clk) disable iff (!rst_n)
        kbd_tx_valid |-> $past(acc && !host_sel));
    a_r4_tx_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(kbd_tx_valid && aux_tx_valid));
    a_r3_mode_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> $stable(mode_q));
endmodule

bind kbc_cmd_engine kbc_cmd_engine_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_wr_valid(host_wr_valid),
    .host_wr_ready(host_wr_ready),
    .host_sel     (host_sel),
    .rsp_valid    (rsp_valid),
    .rsp_ready    (rsp_ready),
    .rsp_data     (rsp_data),
    .rsp_aux      (rsp_aux),
    .kbd_tx_valid (kbd_tx_valid),
    .aux_tx_valid (aux_tx_valid),
    .a20_gate     (a20_gate),
    .sys_reset_req(sys_reset_req),
    .mode_q       (mode_q)
);

// File: tb/kbc_cmd_engine_bench.sv
module kbc_cmd_engine_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr_valid = 1'b0;
    logic       host_sel = 1'b0;
    logic [7:0] host_wdata = '0;
    logic       rsp_ready = 1'b0;
    logic       host_wr_ready, rsp_valid, rsp_aux;
    logic       kbd_tx_valid, aux_tx_valid, a20_gate, sys_reset_req, xlate_en;
    logic [7:0] status_o, rsp_data, dev_tx_data;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    kbc_cmd_engine u_kbc_cmd_engine (
        .clk(clk), .rst_n(rst_n),
        .host_wr_valid(host_wr_valid), .host_wr_ready(host_wr_ready),
        .host_sel(host_sel), .host_wdata(host_wdata), .status_o(status_o),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
        .rsp_aux(rsp_aux), .dev_tx_data(dev_tx_data),
        .kbd_tx_valid(kbd_tx_valid), .aux_tx_valid(aux_tx_valid),
        .a20_gate(a20_gate), .sys_reset_req(sys_reset_req), .xlate_en(xlate_en)
    );

    // Vector: {sel, byte, has_reply, reply_data, reply_aux, req_number}
    localparam int NV = 30;
    localparam logic [22:0] VEC [NV] = '{
        {1'b1, 8'h20, 1'b1, 8'h03, 1'b0, 4'd1},  // R1 mode at reset
        {1'b1, 8'hD0, 1'b1, 8'hCF, 1'b0, 4'd1},  // R1 output port at reset
        {1'b1, 8'hAA, 1'b1, 8'h55, 1'b0, 4'd2},  // R2 self-test
        {1'b1, 8'hA9, 1'b1, 8'h00, 1'b0, 4'd2},  // R2
        {1'b1, 8'hAB, 1'b1, 8'h00, 1'b0, 4'd2},  // R2
        {1'b1, 8'hC0, 1'b1, 8'h80, 1'b0, 4'd2},  // R2
        {1'b1, 8'hA7, 1'b0, 8'h00, 1'b0, 4'd3},  // R3 set bit 5
        {1'b1, 8'h20, 1'b1, 8'h23, 1'b0, 4'd3},
        {1'b1, 8'hAD, 1'b0, 8'h00, 1'b0, 4'd3},  // R3 set bit 4
        {1'b1, 8'h20, 1'b1, 8'h33, 1'b0, 4'd3},
        {1'b1, 8'hA8, 1'b0, 8'h00, 1'b0, 4'd3},  // R3 clear bit 5
        {1'b1, 8'h20, 1'b1, 8'h13, 1'b0, 4'd3},
        {1'b1, 8'hAE, 1'b0, 8'h00, 1'b0, 4'd3},  // R3 clear bit 4
        {1'b1, 8'h20, 1'b1, 8'h03, 1'b0, 4'd3},
        {1'b1, 8'hD2, 1'b0, 8'h00, 1'b0, 4'd4},  // R4 arm keyboard echo
        {1'b0, 8'h5A, 1'b1, 8'h5A, 1'b0, 4'd4},
        {1'b1, 8'hD3, 1'b0, 8'h00, 1'b0, 4'd4},  // R4 arm aux echo
        {1'b0, 8'h3C, 1'b1, 8'h3C, 1'b1, 4'd4},
        {1'b1, 8'h60, 1'b0, 8'h00, 1'b0, 4'd4},  // R4 mode load
        {1'b0, 8'h41, 1'b0, 8'h00, 1'b0, 4'd4},
        {1'b1, 8'h20, 1'b1, 8'h41, 1'b0, 4'd4},
        {1'b1, 8'h60, 1'b0, 8'h00, 1'b0, 4'd4},
        {1'b0, 8'h03, 1'b0, 8'h00, 1'b0, 4'd4},
        {1'b1, 8'hDD, 1'b0, 8'h00, 1'b0, 4'd6},  // R6 A20 off
        {1'b1, 8'hD0, 1'b1, 8'hCD, 1'b0, 4'd6},
        {1'b1, 8'hDF, 1'b0, 8'h00, 1'b0, 4'd6},  // R6 A20 on
        {1'b1, 8'hD0, 1'b1, 8'hCF, 1'b0, 4'd6},
        {1'b1, 8'h12, 1'b0, 8'h00, 1'b0, 4'd9},  // R9 unsupported
        {1'b1, 8'h20, 1'b1, 8'h03, 1'b0, 4'd9},
        {1'b1, 8'hD0, 1'b1, 8'hCF, 1'b0, 4'd9}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one host write; returns at the negedge after the accepting edge.
    task automatic host_wr(input logic sel, input logic [7:0] b);
        @(negedge clk);
        host_wr_valid = 1'b1;
        host_sel      = sel;
        host_wdata    = b;
        while (!host_wr_ready) @(negedge clk);
        @(negedge clk);
        host_wr_valid = 1'b0;
    endtask

    // Take the pending reply out of the slot.
    task automatic drain();
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=%h expected=%h", 8'h01, 8'h00);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 status", status_o, 8'h18);
        chk("R1 a20", {7'd0, a20_gate}, 8'h01);
        chk("R1 rsp_valid", {7'd0, rsp_valid}, 8'h00);
        chk("R1 ready", {7'd0, host_wr_ready}, 8'h01);

        for (int i = 0; i < NV; i++) begin
            logic [22:0] v;
            string tag;
            v = VEC[i];
            tag = $sformatf("R%0d vec%0d", v[3:0], i);
            host_wr(v[22], v[21:14]);
            chk({tag, " valid"}, {7'd0, rsp_valid}, {7'd0, v[13]});
            if (v[13]) begin
                chk({tag, " data"}, rsp_data, v[12:5]);
                chk({tag, " aux"}, {7'd0, rsp_aux}, {7'd0, v[4]});
                drain();
            end
        end

        // R2 self-test left status bit 2 set
        chk("R2 status", status_o, 8'h1C);

        // R11 translation enable follows mode bit 6
        host_wr(1'b1, 8'h60); host_wr(1'b0, 8'h40);
        chk("R11 xlate on", {7'd0, xlate_en}, 8'h01);
        host_wr(1'b1, 8'h60); host_wr(1'b0, 8'h03);
        chk("R11 xlate off", {7'd0, xlate_en}, 8'h00);

        // R7 output port load drives A20 and reset
        host_wr(1'b1, 8'hD1); host_wr(1'b0, 8'hCD);
        chk("R7 a20 low", {7'd0, a20_gate}, 8'h00);
        chk("R7 no reset", {7'd0, sys_reset_req}, 8'h00);
        host_wr(1'b1, 8'hD1); host_wr(1'b0, 8'hCE);
        chk("R7 reset pulse", {7'd0, sys_reset_req}, 8'h01);
        chk("R7 a20 high", {7'd0, a20_gate}, 8'h01);
        @(negedge clk);
        chk("R7 pulse one cycle", {7'd0, sys_reset_req}, 8'h00);
        host_wr(1'b1, 8'hD0);
        chk("R7 outport readback", rsp_data, 8'hCE);
        drain();
        host_wr(1'b1, 8'hD1); host_wr(1'b0, 8'hCF);

        // R8 pulse group
        host_wr(1'b1, 8'hF0);
        chk("R8 F0 reset", {7'd0, sys_reset_req}, 8'h01);
        @(negedge clk);
        chk("R8 F0 one cycle", {7'd0, sys_reset_req}, 8'h00);
        host_wr(1'b1, 8'hF1);
        chk("R8 F1 no-op", {7'd0, sys_reset_req}, 8'h00);
        chk("R8 F1 no reply", {7'd0, rsp_valid}, 8'h00);
        host_wr(1'b1, 8'hFE);
        chk("R8 FE reset", {7'd0, sys_reset_req}, 8'h01);
        host_wr(1'b1, 8'hFF);
        chk("R8 FF no-op", {7'd0, sys_reset_req}, 8'h00);

        // R5 unarmed data goes to the keyboard
        host_wr(1'b0, 8'h77);
        chk("R5 kbd strobe", {7'd0, kbd_tx_valid}, 8'h01);
        chk("R5 kbd byte", dev_tx_data, 8'h77);
        chk("R5 no aux", {7'd0, aux_tx_valid}, 8'h00);
        @(negedge clk);
        chk("R5 strobe one cycle", {7'd0, kbd_tx_valid}, 8'h00);

        // R4 aux forward, then armed code is cleared
        host_wr(1'b1, 8'hD4); host_wr(1'b0, 8'h88);
        chk("R4 aux strobe", {7'd0, aux_tx_valid}, 8'h01);
        chk("R4 aux byte", dev_tx_data, 8'h88);
        chk("R4 no kbd", {7'd0, kbd_tx_valid}, 8'h00);
        host_wr(1'b0, 8'h22);
        chk("R4 cleared to kbd", {7'd0, kbd_tx_valid}, 8'h01);

        // R10 back-pressure
        host_wr(1'b1, 8'h20);
        repeat (3) @(negedge clk);
        chk("R10 held valid", {7'd0, rsp_valid}, 8'h01);
        chk("R10 held data", rsp_data, 8'h03);
        chk("R10 not ready", {7'd0, host_wr_ready}, 8'h00);
        drain();
        chk("R10 ready again", {7'd0, host_wr_ready}, 8'h01);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule